// File: doc/BRIEF.md
# Per-Slave Bus Arbiter with Parking Policy

This block owns the connection of one slave port in a multi-master bus matrix. Each cycle it watches the request lines of up to `N_MST` masters and the transfer shape each one presents: single, fixed-length burst or open-ended burst, plus a burst length and a last-beat flag. It decides on which cycles ownership of the slave may move. On those cycles it picks a winner by round-robin or by fixed priority. Ownership is registered and shown as a one-hot grant vector and as an owner index with a valid flag.

Ownership moves only at clean points. These are an idle owner, a single access, the final beat of a burst, or the expiry of a per-grant slot budget that stops one master from holding the slave too long. When an arbitration point finds no requester, a parking policy sets where the slave rests. It can be left unconnected, left on the most recent winner, or moved to a configured master so that master's next access needs no arbitration.

Top module: `slave_arbiter`

## Requirements
- R1: While rst_ni is low and on the first cycles after it rises with no requests under park type 0, gnt_o is all zero and owner_vld_o is 0.
- R2: With prio_mode_i = 1 (fixed priority), an arbitration point grants the requesting master with the highest index.
- R3: With prio_mode_i = 0 (round-robin), an arbitration point grants the first requester found by searching upward from the master after the previous winner, wrapping past N_MST-1 to 0. After reset the search starts at master 0.
- R4: burst_kind_i holds two bits per master at bits [2i+1:2i]: 0 single, 1 fixed-length burst, 2 open-ended burst, 3 treated as single. A fixed-length burst of burst_len_i beats (LEN_W bits at [LEN_W*i +: LEN_W], where 0 means 1) keeps the grant until its last beat. The beat count clears at each arbitration point.
- R5: An open-ended burst keeps the grant until the owner raises last_beat_i or drops its request.
- R6: Every active cycle of a single access is an arbitration point.
- R7: With slot_lim_i = L nonzero, the L-th consecutive active cycle since the latest arbitration point is an arbitration point even inside a burst. With L = 0 no break occurs.
- R8: Park type 0 or 3: an arbitration point with no requester leaves the slave unconnected.
- R9: Park type 1: an arbitration point with no requester keeps the slave on the most recent winner, or unconnected if none has been granted since reset.
- R10: Park type 2: an arbitration point with no requester connects the slave to park_idx_i. While parked, the slave follows changes of park_idx_i.
- R11: Ownership changes only in the cycle after an arbitration point. gnt_o is one-hot on owner_o when owner_vld_o is 1 and zero otherwise.
- R12: A cycle where no master is connected, or the connected master's request is low, is an arbitration point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | N_MST | Per-master access request |
| burst_kind_i | input | 2*N_MST | Per-master transfer shape |
| burst_len_i | input | N_MST*LEN_W | Per-master burst length in beats |
| last_beat_i | input | N_MST | Per-master final beat of open-ended burst |
| prio_mode_i | input | 1 | 0 round-robin, 1 fixed priority |
| park_type_i | input | 2 | Parking policy |
| park_idx_i | input | IDX_W | Master to park on under policy 2 |
| slot_lim_i | input | CNT_W | Slot budget in active cycles, 0 disables |
| gnt_o | output | N_MST | One-hot grant |
| owner_o | output | IDX_W | Index of connected master |
| owner_vld_o | output | 1 | Slave is connected |

## Verification
The bench builds the arbiter with four masters, 3-bit burst lengths and a 3-bit slot counter. With these sizes, round-robin wrap-around, saturation of both counters and slot budgets shorter than, equal to and longer than a burst all occur within a few hundred cycles. Each phase holds one policy and arbitration mode and varies request density, burst lengths, last-beat timing and the park index. A behavioural model is compared on every cycle against the grant, the owner and its valid flag.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    PARK_NONE  = 2'd0,
    PARK_LAST  = 2'd1,
    PARK_FIXED = 2'd2,
    PARK_RSVD  = 2'd3
  } park_type_e;

  typedef enum logic [1:0] {
    BK_SINGLE  = 2'd0,
    BK_DEFINED = 2'd1,
    BK_OPEN    = 2'd2,
    BK_RSVD    = 2'd3
  } burst_kind_e;
endpackage

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int N_MST = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_MST-1:0] req_i,
  input  logic [IDX_W-1:0] ptr_i,
  input  logic             fixed_i,
  output logic             any_o,
  output logic [IDX_W-1:0] win_o
);
  logic             hi_f;
  logic [IDX_W-1:0] hi_w, lo_w, fx_w;

  always_comb begin
    hi_f = 1'b0;
    hi_w = '0;
    lo_w = '0;
    fx_w = '0;
    // downward scan: last hit is the lowest index above / at-or-below ptr
    for (int i = N_MST-1; i >= 0; i--) begin
      if (req_i[i]) begin
        if (IDX_W'(i) > ptr_i) begin
          hi_f = 1'b1;
          hi_w = IDX_W'(i);
        end else begin
          lo_w = IDX_W'(i);
        end
      end
    end
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i]) fx_w = IDX_W'(i);
    end
  end

  assign any_o = |req_i;
  assign win_o = fixed_i ? fx_w : (hi_f ? hi_w : lo_w);
endmodule

// File: rtl/arb_rearb.sv
module arb_rearb
  import arb_pkg::*;
#(
  parameter int N_MST = 16,
  parameter int IDX_W = 4,
  parameter int LEN_W = 4,
  parameter int CNT_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               own_vld_i,
  input  logic [IDX_W-1:0]   own_idx_i,
  input  logic [N_MST-1:0]   req_i,
  input  logic [2*N_MST-1:0] kind_i,
  input  logic [N_MST*LEN_W-1:0] len_i,
  input  logic [N_MST-1:0]   last_i,
  input  logic [CNT_W-1:0]   slot_lim_i,
  output logic               arb_pt_o
);
  logic [1:0]       kind_a [N_MST];
  logic [LEN_W-1:0] len_a  [N_MST];

  for (genvar g = 0; g < N_MST; g++) begin : g_split
    assign kind_a[g] = kind_i[2*g +: 2];
    assign len_a[g]  = len_i[LEN_W*g +: LEN_W];
  end

  logic [LEN_W-1:0] beat_q;
  logic [CNT_W-1:0] slot_q;
  logic             own_act, beat_end, slot_hit;
  burst_kind_e      kind;

  assign own_act  = own_vld_i && req_i[own_idx_i];
  assign kind     = burst_kind_e'(kind_a[own_idx_i]);
  assign beat_end = ({1'b0, beat_q} + (LEN_W+1)'(1)) >= {1'b0, len_a[own_idx_i]};
  assign slot_hit = (slot_lim_i != '0) &&
                    (({1'b0, slot_q} + (CNT_W+1)'(1)) >= {1'b0, slot_lim_i});

  always_comb begin
    unique case (kind)
      BK_DEFINED: arb_pt_o = beat_end;
      BK_OPEN:    arb_pt_o = last_i[own_idx_i];
      default:    arb_pt_o = 1'b1;
    endcase
    if (!own_act || slot_hit) arb_pt_o = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      slot_q <= '0;
    end else if (arb_pt_o) begin
      beat_q <= '0;
      slot_q <= '0;
    end else if (own_act) begin
      if (!(&beat_q)) beat_q <= beat_q + LEN_W'(1);
      if (!(&slot_q)) slot_q <= slot_q + CNT_W'(1);
    end
  end

  // R7: slot budget always forces a break
  assert_slot_break_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_act && slot_lim_i != '0 && $stable(slot_lim_i) && !$past(arb_pt_o) &&
     slot_q == slot_lim_i - CNT_W'(1)) |-> arb_pt_o);
endmodule

// File: rtl/slave_arbiter.sv
module slave_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST = 16,
  parameter int LEN_W = 4,
  parameter int CNT_W = 8,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_MST-1:0]       req_i,
  input  logic [2*N_MST-1:0]     burst_kind_i,
  input  logic [N_MST*LEN_W-1:0] burst_len_i,
  input  logic [N_MST-1:0]       last_beat_i,
  input  logic                   prio_mode_i,
  input  logic [1:0]             park_type_i,
  input  logic [IDX_W-1:0]       park_idx_i,
  input  logic [CNT_W-1:0]       slot_lim_i,
  output logic [N_MST-1:0]       gnt_o,
  output logic [IDX_W-1:0]       owner_o,
  output logic                   owner_vld_o
);
  logic             own_vld_q, seen_q, arb_pt, any_req, park_ok;
  logic [IDX_W-1:0] own_idx_q, ptr_q, win;

  arb_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
    .req_i   (req_i),
    .ptr_i   (ptr_q),
    .fixed_i (prio_mode_i),
    .any_o   (any_req),
    .win_o   (win)
  );

  arb_rearb #(.N_MST(N_MST), .IDX_W(IDX_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rearb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .own_vld_i  (own_vld_q),
    .own_idx_i  (own_idx_q),
    .req_i      (req_i),
    .kind_i     (burst_kind_i),
    .len_i      (burst_len_i),
    .last_i     (last_beat_i),
    .slot_lim_i (slot_lim_i),
    .arb_pt_o   (arb_pt)
  );

  if (N_MST == (1 << IDX_W)) begin : g_park_full
    assign park_ok = 1'b1;
  end else begin : g_park_chk
    assign park_ok = park_idx_i < IDX_W'(N_MST);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_vld_q <= 1'b0;
      own_idx_q <= '0;
      ptr_q     <= IDX_W'(N_MST-1);
      seen_q    <= 1'b0;
    end else if (arb_pt) begin
      if (any_req) begin
        own_vld_q <= 1'b1;
        own_idx_q <= win;
        ptr_q     <= win;
        seen_q    <= 1'b1;
      end else begin
        unique case (park_type_e'(park_type_i))
          PARK_LAST: begin
            own_vld_q <= seen_q;
            own_idx_q <= ptr_q;
          end
          PARK_FIXED: begin
            own_vld_q <= park_ok;
            own_idx_q <= park_idx_i;
          end
          default: own_vld_q <= 1'b0;
        endcase
      end
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_gnt
    assign gnt_o[g] = own_vld_q && (own_idx_q == IDX_W'(g));
  end
  assign owner_o     = own_idx_q;
  assign owner_vld_o = own_vld_q;

  assert_unpark_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_pt && !any_req && (park_type_i == PARK_NONE || park_type_i == PARK_RSVD))
    |=> !owner_vld_o);

  assert_park_fixed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_pt && !any_req && park_type_i == PARK_FIXED && park_ok)
    |=> owner_vld_o && owner_o == $past(park_idx_i));

  assert_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arb_pt |=> $stable(owner_o) && $stable(owner_vld_o));

  assert_take_win_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_pt && any_req) |=> owner_vld_o && owner_o == $past(win));

  assert_gnt_shape_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (owner_vld_o == (gnt_o != '0)));
endmodule

// File: tb/sim_slave_arbiter.sv
module sim_slave_arbiter;
  localparam int N  = 4;
  localparam int LW = 3;
  localparam int CW = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [N-1:0]    req = '0;
  logic [2*N-1:0]  kind = '0;
  logic [N*LW-1:0] blen = '0;
  logic [N-1:0]    last = '0;
  logic            prio = 1'b0;
  logic [1:0]      ptype = 2'd0;
  logic [IW-1:0]   pidx = '0;
  logic [CW-1:0]   lim = '0;
  logic [N-1:0]    gnt;
  logic [IW-1:0]   own;
  logic            own_vld;

  slave_arbiter #(.N_MST(N), .LEN_W(LW), .CNT_W(CW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .burst_kind_i(kind),
    .burst_len_i(blen), .last_beat_i(last), .prio_mode_i(prio),
    .park_type_i(ptype), .park_idx_i(pidx), .slot_lim_i(lim),
    .gnt_o(gnt), .owner_o(own), .owner_vld_o(own_vld)
  );

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 1'b0;

  // reference model state
  int m_vld, m_idx, m_ptr, m_seen, m_beat, m_slot;

  task automatic check(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step();
    int  k, ln, w;
    bit  act, arb;
    act = (m_vld != 0) && req[m_idx];
    k   = int'(kind[2*m_idx +: 2]);
    ln  = int'(blen[m_idx*LW +: LW]);
    arb = !act || k == 0 || k == 3 || (k == 1 && m_beat + 1 >= ln) ||
          (k == 2 && last[m_idx]) || (lim != 0 && m_slot + 1 >= int'(lim));
    if (!arb) begin
      m_beat++;
      m_slot++;
      return;
    end
    m_beat = 0;
    m_slot = 0;
    if (req != 0) begin
      w = -1;
      if (prio) begin
        for (int i = 0; i < N; i++) if (req[i]) w = i;
      end else begin
        for (int s = 1; s <= N; s++)
          if (w < 0 && req[(m_ptr + s) % N]) w = (m_ptr + s) % N;
      end
      m_vld = 1; m_idx = w; m_ptr = w; m_seen = 1;
    end else if (ptype == 2'd1) begin
      m_vld = m_seen; m_idx = m_ptr;
    end else if (ptype == 2'd2) begin
      m_vld = 1; m_idx = int'(pidx);
    end else begin
      m_vld = 0;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_idx = 0; m_ptr = N-1; m_seen = 0; m_beat = 0; m_slot = 0;
    end else begin
      model_step();
    end
  end

  task automatic cycle_cmp();
    int eg;
    @(negedge clk);
    eg = m_vld ? (1 << m_idx) : 0;
    check(int'(gnt) == eg, "gnt_o", int'(gnt), eg);
    check(int'(own_vld) == m_vld, "owner_vld_o", int'(own_vld), m_vld);
    if (m_vld != 0) check(int'(own) == m_idx, "owner_o", int'(own), m_idx);
  endtask

  function automatic logic [N-1:0] rnd_bits(int pct);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ($urandom % 100) < pct;
    return v;
  endfunction

  task automatic run(string t, int cyc, int p_req, int p_last, bit vary_park);
    tag = t;
    for (int c = 0; c < cyc; c++) begin
      cycle_cmp();
      req  = rnd_bits(p_req);
      last = rnd_bits(p_last);
      if (vary_park && (c % 23) == 0) pidx = IW'($urandom);
      if ((c % 40) == 0) blen = (N*LW)'($urandom);
    end
  endtask

  task automatic all_kind(int k);
    for (int i = 0; i < N; i++) kind[2*i +: 2] = 2'(k);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    check(gnt == '0, "gnt_o in reset", int'(gnt), 0);
    check(own_vld == 1'b0, "owner_vld_o in reset", int'(own_vld), 0);
    rst_n = 1'b1;
    run("R1", 4, 0, 0, 0);
    // R6 and R3: singles, round-robin, all requesting -> rotation each cycle
    all_kind(0);
    run("R6", 40, 100, 0, 0);
    run("R3", 300, 50, 0, 0);
    prio = 1'b1;
    run("R2", 300, 50, 0, 0);
    all_kind(1);
    prio = 1'b0;
    run("R4", 300, 92, 0, 0);
    all_kind(3);
    run("R4 kind3", 100, 60, 0, 0);
    all_kind(2);
    run("R5", 300, 95, 15, 0);
    lim = 3'd0;
    run("R7 no limit", 150, 100, 0, 0);
    lim = 3'd3;
    run("R7", 200, 100, 0, 0);
    all_kind(1);
    lim = 3'd2;
    run("R7 burst", 200, 95, 0, 0);
    lim = 3'd0;
    all_kind(0);
    ptype = 2'd0;
    run("R8", 200, 15, 0, 0);
    ptype = 2'd3;
    run("R8 type3", 150, 15, 0, 0);
    ptype = 2'd1;
    run("R9", 250, 15, 0, 0);
    ptype = 2'd2;
    run("R10", 300, 10, 0, 1);
    all_kind(1);
    ptype = 2'd1;
    run("R12", 300, 60, 0, 0);
    // R11: mixed everything
    for (int p = 0; p < 6; p++) begin
      kind  = (2*N)'($urandom);
      prio  = p[0];
      ptype = 2'(p);
      lim   = CW'($urandom);
      run("R11", 150, 55, 20, 1);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R11 watchdog: actual not finished expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule